// File: doc/BRIEF.md
# Single-Wire Parity Chunk Serializer

This block moves short words of one to eight bits across a single shared data line that idles high through a pull-up. In transmit mode it presents the chosen number of bits, most significant first, for one full bit period each. It then appends a single parity bit. A one releases the line and a zero pulls it low, and the block reports this on separate drive-enable and drive-value outputs. In receive mode it first waits a start-adjust delay. It then samples each bit near its midpoint, checks the parity bit that follows the data, and returns the word right-aligned with an error flag.

Bit timing is set by parameters in system-clock cycles. One down-counter produces the full bit period for transmit, and the split half periods plus a width-adjust for receive. The half periods are floor(T/2) before the sample point and the remaining T-floor(T/2) after it, so an odd period still adds up to T. A caller starts one chunk with a start strobe, then waits for the one-cycle done pulse. A receive result should be rejected when the error flag is set.

Top module: `pchunk_serdes`

## Requirements
- R1: After reset the block is idle. `line_oe`=0, `line_out`=1, `done`=0, `rx_data`=0 and `par_err`=0.
- R2: A start with `dir_rx`=0 begins a transmit in the cycle after the start edge. Data bit n (n=0 is bit width-1, the MSB) is presented for BIT_CYC cycles, from cycle n*BIT_CYC after the start edge.
- R3: After the data bits, one parity bit is presented for BIT_CYC cycles. Its value is `odd_par` XOR the XOR of all sent data bits, so `odd_par`=0 gives even parity and 1 gives odd parity.
- R4: While a bit is presented, a 1 gives `line_oe`=0 and `line_out`=1 (line released), and a 0 gives `line_oe`=1 and `line_out`=0. Outside transmit, `line_oe`=0 and `line_out`=1.
- R5: A transmit ends with `done` high for exactly one cycle, (width+1)*BIT_CYC cycles after the start edge.
- R6: A `width` value of 0, or one greater than DATA_W, is treated as DATA_W bits.
- R7: A start with `dir_rx`=1 begins a receive. Bit n (n=0 is the MSB, n=width is parity) is sampled from `line_in` at edge START_ADJ + n*(BIT_CYC+WIDTH_ADJ) + floor(BIT_CYC/2) after the start edge. The word is returned right-aligned in `rx_data` with zero upper bits.
- R8: `par_err` is set after a receive when the sampled parity bit differs from `odd_par` XOR the XOR of the received data bits, and is cleared otherwise.
- R9: A receive pulses `done` for one cycle right after the parity sample. `rx_data` and `par_err` change only in that cycle. The block never drives the line while receiving.
- R10: A start strobe while a transfer is in progress (before its done cycle) is ignored, as are changes of the other inputs. A start during the done cycle is accepted.
- R11: With an odd BIT_CYC, the sample point is floor(BIT_CYC/2) cycles into the bit, and consecutive samples are exactly BIT_CYC+WIDTH_ADJ cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start one chunk transfer (accepted when idle) |
| dir_rx | input | 1 | 1 = receive, 0 = transmit |
| width | input | $clog2(DATA_W+1) | Chunk bit count, 1..DATA_W (0 or larger means DATA_W) |
| tx_data | input | DATA_W | Word to transmit, right-aligned |
| odd_par | input | 1 | Parity mode: 0 even, 1 odd |
| line_in | input | 1 | Level of the shared data line |
| line_oe | output | 1 | Pull the line low |
| line_out | output | 1 | Value presented on the line (1 = released) |
| rx_data | output | DATA_W | Last received word, right-aligned |
| done | output | 1 | One-cycle end-of-chunk pulse |
| par_err | output | 1 | Parity mismatch of the last receive |

## Verification
Transmit outputs change on the start edge itself, so each data bit is due from cycle n*BIT_CYC after it and `done` is due at (width+1)*BIT_CYC. A receive reads `line_in` in the cycle before edge START_ADJ + n*(BIT_CYC+WIDTH_ADJ) + floor(BIT_CYC/2), and its `done`, `rx_data` and `par_err` are due in the cycle that follows the parity sample edge. The bench counts edges from the accepted start and compares every output mid-cycle against a behavioural model. When receiving, it holds the correct bit level only in the single cycle before each due sample edge and the inverted level otherwise, so a sample taken one cycle early or late returns a wrong word or parity.

// File: rtl/pchunk_pkg.sv
package pchunk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_TX_BIT = 3'd1,
        ST_TX_PAR = 3'd2,
        ST_RX_ADJ = 3'd3,
        ST_RX_H1  = 3'd4,
        ST_RX_H2  = 3'd5
    } pchunk_state_e;

endpackage

// File: rtl/pchunk_timer.sv
// Loadable down-counter; expire is high while the count sits at zero.
module pchunk_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/pchunk_par_acc.sv
// Running parity: seeded with the mode, toggled by every 1 bit.
module pchunk_par_acc (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic init_val,
    input  logic tog,
    input  logic tog_bit,
    output logic acc
);

    logic acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (init)     acc_d = init_val;
        else if (tog) acc_d = acc_q ^ tog_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= 1'b0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;

endmodule

// File: rtl/pchunk_serdes.sv
module pchunk_serdes
    import pchunk_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BIT_CYC   = 300,
    parameter int START_ADJ = 40,
    parameter int WIDTH_ADJ = 4,
    localparam int WW       = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_rx,
    input  logic [WW-1:0]     width,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              odd_par,
    input  logic              line_in,
    output logic              line_oe,
    output logic              line_out,
    output logic [DATA_W-1:0] rx_data,
    output logic              done,
    output logic              par_err
);

    localparam int H1    = BIT_CYC / 2;
    localparam int H2    = BIT_CYC - H1;
    localparam int L_BIT = BIT_CYC - 1;
    localparam int L_ADJ = START_ADJ - 1;
    localparam int L_H1  = H1 - 1;
    localparam int L_H2  = H2 + WIDTH_ADJ - 1;
    localparam int L_M1  = (L_BIT > L_ADJ) ? L_BIT : L_ADJ;
    localparam int L_MAX = (L_M1 > L_H2) ? L_M1 : L_H2;
    localparam int CW    = (L_MAX < 1) ? 1 : $clog2(L_MAX + 1);

    typedef struct packed {
        pchunk_state_e     state;
        logic [WW-1:0]     bits;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rxd;
        logic              err;
        logic              done;
    } ctl_t;

    ctl_t          d, q;
    logic          t_load, t_exp;
    logic [CW-1:0] t_val;
    logic          p_init, p_tog, p_bit, p_acc;
    logic [WW-1:0] w_eff;
    logic          tx_act, cur_bit;

    pchunk_timer #(.CW(CW)) timer_i (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expire(t_exp)
    );

    pchunk_par_acc par_i (
        .clk(clk), .rst_n(rst_n), .init(p_init), .init_val(odd_par),
        .tog(p_tog), .tog_bit(p_bit), .acc(p_acc)
    );

    assign w_eff = (width == '0 || width > WW'(DATA_W)) ? WW'(DATA_W) : width;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        t_load = 1'b0;
        t_val  = '0;
        p_init = 1'b0;
        p_tog  = 1'b0;
        p_bit  = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    p_init = 1'b1;
                    t_load = 1'b1;
                    d.bits = w_eff;
                    if (dir_rx) begin
                        d.state = ST_RX_ADJ;
                        t_val   = CW'(L_ADJ);
                        d.sh    = '0;
                    end else begin
                        d.state = ST_TX_BIT;
                        t_val   = CW'(L_BIT);
                        d.sh    = tx_data << (DATA_W - int'(w_eff));
                    end
                end
            end
            ST_TX_BIT: begin
                if (t_exp) begin
                    p_tog  = 1'b1;
                    p_bit  = q.sh[DATA_W-1];
                    d.sh   = q.sh << 1;
                    d.bits = q.bits - 1'b1;
                    t_load = 1'b1;
                    t_val  = CW'(L_BIT);
                    if (q.bits == WW'(1)) d.state = ST_TX_PAR;
                end
            end
            ST_TX_PAR: begin
                if (t_exp) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                end
            end
            ST_RX_ADJ: begin
                if (t_exp) begin
                    d.state = ST_RX_H1;
                    t_load  = 1'b1;
                    t_val   = CW'(L_H1);
                end
            end
            ST_RX_H1: begin
                if (t_exp) begin
                    if (q.bits != '0) begin
                        p_tog   = 1'b1;
                        p_bit   = line_in;
                        d.sh    = {q.sh[DATA_W-2:0], line_in};
                        d.bits  = q.bits - 1'b1;
                        d.state = ST_RX_H2;
                        t_load  = 1'b1;
                        t_val   = CW'(L_H2);
                    end else begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                        d.rxd   = q.sh;
                        d.err   = p_acc ^ line_in;
                    end
                end
            end
            ST_RX_H2: begin
                if (t_exp) begin
                    d.state = ST_RX_H1;
                    t_load  = 1'b1;
                    t_val   = CW'(L_H1);
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_act   = (q.state == ST_TX_BIT) || (q.state == ST_TX_PAR);
    assign cur_bit  = (q.state == ST_TX_BIT) ? q.sh[DATA_W-1] : p_acc;
    assign line_oe  = tx_act & ~cur_bit;
    assign line_out = ~tx_act | cur_bit;
    assign rx_data  = q.rxd;
    assign done     = q.done;
    assign par_err  = q.err;

    // R1: an idle block leaves the line released
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE) |-> (!line_oe && line_out));

    // R2: a data bit holds until the bit timer expires
    a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_TX_BIT && !t_exp) |=> $stable(line_oe));

    // R5: done lasts a single cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: nothing is driven while receiving
    a_r9_rx_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RX_ADJ || q.state == ST_RX_H1 || q.state == ST_RX_H2) |-> !line_oe);

    // R9: results only move in the done cycle
    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(rx_data) && $stable(par_err)));

endmodule

// File: tb/pchunk_serdes_tb_top.sv
module pchunk_serdes_tb_top;

    localparam int DW = 8;
    localparam int T  = 9;
    localparam int S  = 3;
    localparam int WA = 2;
    localparam int H1 = T / 2;
    localparam int WW = $clog2(DW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          dir_rx = 1'b0;
    logic [WW-1:0] width = '0;
    logic [DW-1:0] tx_data = '0;
    logic          odd_par = 1'b0;
    logic          line_in = 1'b1;
    logic          line_oe, line_out, done, par_err;
    logic [DW-1:0] rx_data;

    always #10 clk = ~clk;

    pchunk_serdes #(.DATA_W(DW), .BIT_CYC(T), .START_ADJ(S), .WIDTH_ADJ(WA)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_rx(dir_rx), .width(width),
        .tx_data(tx_data), .odd_par(odd_par), .line_in(line_in),
        .line_oe(line_oe), .line_out(line_out), .rx_data(rx_data),
        .done(done), .par_err(par_err)
    );

    int total = 0;
    int bad   = 0;

    // behavioural model state
    int        m_mode = 0;   // 0 idle, 1 transmit, 2 receive
    int        u = 0;        // edges since the accepted start edge
    int        endu = 0;
    int        mw = 0;
    logic [DW-1:0] mdata = '0;
    logic      mpar = 1'b0;
    logic      seq [0:DW];
    logic [DW-1:0] m_rxd = '0;
    logic      m_err = 1'b0;
    logic [DW-1:0] next_rxd = '0;
    logic      next_err = 1'b0;
    logic [DW:0] recon = '0;
    logic      rx_corrupt = 1'b0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (u=%0d)", tag, act, exp, u);
        end
    endtask

    function automatic int samp(input int n);
        return S + n * (T + WA) + H1;
    endfunction

    function automatic int eff_w(input int w);
        return (w == 0 || w > DW) ? DW : w;
    endfunction

    task automatic step();
        logic busy, bitv, eo, eout, ed;
        string tg;
        @(posedge clk);
        #1;
        busy = (m_mode != 0) && (u < endu);
        if (m_mode != 0) begin
            u++;
            if (u > endu) m_mode = 0;
        end
        if (start && !busy) begin
            mw    = eff_w(int'(width));
            mdata = tx_data & DW'((1 << mw) - 1);
            mpar  = odd_par ^ (^mdata);
            u     = 0;
            recon = '0;
            if (dir_rx) begin
                m_mode = 2;
                endu   = samp(mw);
                for (int n = 0; n < mw; n++) seq[n] = mdata[mw-1-n];
                seq[mw]  = mpar ^ rx_corrupt;
                next_rxd = mdata;
                next_err = rx_corrupt;
            end else begin
                m_mode = 1;
                endu   = (mw + 1) * T;
            end
        end
        if (m_mode == 2 && u == endu) begin
            m_rxd = next_rxd;
            m_err = next_err;
        end
        // drive the line for a receive: right level only just before each sample edge
        line_in = 1'b1;
        if (m_mode == 2 && u < endu) begin
            for (int n = 0; n <= mw; n++) begin
                if (samp(n) - 1 >= u) begin
                    line_in = (u == samp(n) - 1) ? seq[n] : ~seq[n];
                    break;
                end
            end
        end
        #9;
        eo = 1'b0; eout = 1'b1; tg = (m_mode == 2) ? "R9" : "R1";
        if (m_mode == 1 && u < endu) begin
            bitv = (u < mw * T) ? mdata[mw-1-(u/T)] : mpar;
            tg   = (u < mw * T) ? "R2/R4" : "R3/R4";
            eo   = ~bitv;
            eout = bitv;
            if (u % T == H1) recon = {recon[DW-1:0], line_out};
        end
        ed = (m_mode != 0) && (u == endu);
        chk(line_oe == eo, tg, line_oe, eo);
        chk(line_out == eout, tg, line_out, eout);
        chk(done == ed, (m_mode == 2) ? "R9" : "R5", done, ed);
        chk(rx_data == m_rxd, "R7", rx_data, m_rxd);
        chk(par_err == m_err, "R8", par_err, m_err);
    endtask

    task automatic finish_xfer();
        while (m_mode != 0) step();
        step();
    endtask

    task automatic run_tx(input int w, input logic [DW-1:0] dat, input logic odd, input string tag);
        logic [DW:0] want;
        int we;
        dir_rx = 1'b0; width = WW'(w); tx_data = dat; odd_par = odd;
        start = 1'b1; step(); start = 1'b0;
        finish_xfer();
        we   = eff_w(w);
        want = ({1'b0, dat & DW'((1 << we) - 1)} << 1) | (DW+1)'(odd ^ (^(dat & DW'((1 << we) - 1))));
        chk(recon == want, tag, recon, want);
    endtask

    task automatic run_rx(input int w, input logic [DW-1:0] dat, input logic odd,
                          input logic bad_par, input string tag);
        int we;
        dir_rx = 1'b1; width = WW'(w); tx_data = dat; odd_par = odd; rx_corrupt = bad_par;
        start = 1'b1; step(); start = 1'b0;
        finish_xfer();
        we = eff_w(w);
        chk(rx_data == (dat & DW'((1 << we) - 1)), tag, rx_data, dat & DW'((1 << we) - 1));
        chk(par_err == bad_par, "R8", par_err, bad_par);
    endtask

    initial begin
        #(20 * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        #5;
        chk(line_oe == 1'b0 && line_out == 1'b1, "R1", {line_oe, line_out}, 2'b01);
        chk(done == 1'b0 && rx_data == '0 && par_err == 1'b0, "R1", {done, rx_data, par_err}, 0);
        step(); step();

        run_tx(8, 8'hA5, 1'b0, "R2 msb-first even");
        run_tx(3, 8'hFD, 1'b1, "R3 odd parity w=3");
        run_tx(1, 8'h01, 1'b0, "R3 single bit");
        run_tx(0, 8'h81, 1'b0, "R6 width 0");
        run_tx(12, 8'h3C, 1'b1, "R6 width over");

        // R10: restart attempts and input changes mid-transfer are ignored
        dir_rx = 1'b0; width = WW'(4); tx_data = 8'h09; odd_par = 1'b0;
        start = 1'b1; step(); start = 1'b0;
        repeat (10) step();
        dir_rx = 1'b1; width = WW'(7); tx_data = 8'hFF; odd_par = 1'b1;
        start = 1'b1; step(); step(); start = 1'b0;
        finish_xfer();
        chk(recon == 5'b10010, "R10 ignored restart", recon, 5'b10010);

        run_rx(8, 8'hC3, 1'b0, 1'b0, "R7 rx w=8");
        run_rx(5, 8'h16, 1'b1, 1'b1, "R8 corrupt parity");
        run_rx(1, 8'h01, 1'b1, 1'b0, "R11 rx w=1");
        run_rx(0, 8'h5A, 1'b0, 1'b0, "R6 rx width 0");
        run_rx(6, 8'h2B, 1'b0, 1'b1, "R11 odd period w=6");

        // R10: start during the done cycle is accepted (back-to-back)
        dir_rx = 1'b0; width = WW'(2); tx_data = 8'h02; odd_par = 1'b0;
        start = 1'b1; step(); start = 1'b0;
        while (!(m_mode == 1 && u == endu - 1)) step();
        width = WW'(2); tx_data = 8'h01; start = 1'b1; step(); step(); start = 1'b0;
        chk(m_mode == 1 && u == 0, "R10 back-to-back", u, 0);
        finish_xfer();
        chk(recon == 3'b011, "R10 second chunk", recon, 3'b011);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule